// File: doc/BRIEF.md
# Memory Region Decoder and Wait-State Sequencer

This block sits on the access path of a 32-bit bus master. For each request it takes the address, an access size code, the direction and a sequential flag. It works out which of nine memory regions the address falls in and checks whether that region permits the size and direction. It then runs a fixed wait-state count for the access and drives a one-hot select for the region for the whole access. When a 32-bit access targets a 16-bit region, the block issues two half-word strobes. It raises a one-cycle ready on the last cycle. Accesses that are illegal or unmapped finish at once with an error flag.

Timings are fixed defaults. Each access time is set by three things: the bus width of the region, the access size, and a video-contention input. The master may present its next request in the cycle that ready is high, so accesses can run back to back with no idle cycle between them.

Top module: `mem_region_wait`

## Requirements
- R1: The address decodes to a one-hot `region_sel` bit, and `region_sel` is held for every cycle of the access. The bit index is the region: 0 boot ROM 0x0000_0000–0x0000_3FFF, 1 external work RAM 0x0200_0000–0x0203_FFFF, 2 internal work RAM 0x0300_0000–0x0300_7FFF, 3 I/O 0x0400_0000–0x0400_03FF, 4 palette 0x0500_0000–0x0500_03FF, 5 video RAM 0x0600_0000–0x0601_7FFF, 6 object attribute memory 0x0700_0000–0x0700_03FF, 7 cartridge ROM 0x0800_0000–0x0DFF_FFFF, 8 save RAM 0x0E00_0000–0x0E00_FFFF.
- R2: `req_size` is 0 for byte, 1 for half-word and 2 for word. Boot ROM, internal work RAM, I/O and object attribute memory take 1 cycle at every size.
- R3: External work RAM takes 3 cycles for byte and half-word accesses and 6 cycles for word accesses.
- R4: Palette and video RAM take 1 cycle for byte and half-word accesses and 2 cycles for word accesses.
- R5: When `vid_busy` is high at the acceptance edge, a palette, video RAM or object attribute memory access takes one more cycle. All other regions ignore `vid_busy`.
- R6: Cartridge ROM takes 5 cycles for byte and half-word accesses and 8 cycles for word accesses.
- R7: Save RAM takes 5 cycles and accepts only byte accesses, for both reads and writes.
- R8: These requests finish in 1 cycle with `err` and `rdy` high, no `region_sel` bit and no `strobe`: an unmapped address, a write to boot ROM or cartridge ROM, a byte write to palette, video RAM or object attribute memory, a non-byte access to save RAM, and size code 3.
- R9: Every legal access strobes in its first cycle with `strobe_addr` equal to the request address. A word access to a 16-bit region strobes a second time with address+2. That second strobe comes in cycle 1 for palette and video RAM, cycle 3 for external work RAM and cycle 5 for cartridge ROM.
- R10: `rdy` is high for exactly one cycle, the final one. A request is accepted only when the block is idle or `rdy` is high. Requests presented mid-access are ignored.
- R11: `req_seq` does not change the latency of any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_write | input | 1 | 1 for write |
| req_seq | input | 1 | Sequential-access hint |
| vid_busy | input | 1 | Video engine is using video memory |
| region_sel | output | 9 | One-hot region select for the running access |
| strobe | output | 1 | Bus transfer strobe |
| strobe_addr | output | 32 | Address of the current transfer |
| rdy | output | 1 | Final cycle of an access |
| err | output | 1 | Access rejected (with rdy) |

## Verification
A request is taken at the clock edge where `req_valid` is high and the block is idle or `rdy` is high. All outputs for the access appear in the cycle after that edge, which is cycle 0. An access of N cycles raises `rdy` in cycle N-1. The second strobe appears in the cycle given by R9. The bench's model computes N, the region and the strobe cycles from the requirements. It then compares every output at every falling edge from cycle 0 through cycle N-1. Where the next request is chained into the `rdy` cycle, the bench drives it on that same falling edge. Where an access is followed by an idle cycle, the bench checks that cycle separately.

// File: rtl/mrw_pkg.sv
`timescale 1ns/1ps
package mrw_pkg;
    localparam int NUM_REGIONS = 9;

    typedef enum logic [3:0] {
        RG_BOOT  = 4'd0,
        RG_XWRAM = 4'd1,
        RG_IWRAM = 4'd2,
        RG_IO    = 4'd3,
        RG_PAL   = 4'd4,
        RG_VRAM  = 4'd5,
        RG_OAM   = 4'd6,
        RG_CART  = 4'd7,
        RG_SAVE  = 4'd8,
        RG_NONE  = 4'd15
    } region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_RSV  = 2'd3;
endpackage

// File: rtl/region_decode.sv
`timescale 1ns/1ps
module region_decode
    import mrw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    logic        top_zero;
    logic [3:0]  page;
    logic [23:0] offs;

    always_comb begin
        top_zero = (addr[ADDR_W-1:28] == '0);
        page     = addr[27:24];
        offs     = addr[23:0];
        region   = RG_NONE;
        if (top_zero) begin
            unique case (page)
                4'h0: if (offs < 24'h00_4000) region = RG_BOOT;
                4'h2: if (offs < 24'h04_0000) region = RG_XWRAM;
                4'h3: if (offs < 24'h00_8000) region = RG_IWRAM;
                4'h4: if (offs < 24'h00_0400) region = RG_IO;
                4'h5: if (offs < 24'h00_0400) region = RG_PAL;
                4'h6: if (offs < 24'h01_8000) region = RG_VRAM;
                4'h7: if (offs < 24'h00_0400) region = RG_OAM;
                4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: region = RG_CART;
                4'hE: if (offs < 24'h01_0000) region = RG_SAVE;
                default: region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/access_cost.sv
`timescale 1ns/1ps
module access_cost
    import mrw_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int XW_NARROW = 3,
    parameter int XW_WIDE   = 6,
    parameter int VID_WIDE  = 2,
    parameter int CART_NARR = 5,
    parameter int CART_WIDE = 8,
    parameter int SAVE_COST = 5
) (
    input  region_e          region,
    input  logic [1:0]       size,
    input  logic             write,
    input  logic             vid_busy,
    output logic             legal,
    output logic             split,
    output logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] half
);
    logic             word;
    logic             vid_region;
    logic [CNT_W-1:0] base;

    always_comb begin
        word       = (size == SZ_WORD);
        vid_region = 1'b0;
        legal      = 1'b1;
        split      = 1'b0;
        base       = CNT_W'(1);
        half       = CNT_W'(1);
        unique case (region)
            RG_BOOT:           legal = !write;
            RG_IWRAM, RG_IO:   legal = 1'b1;
            RG_OAM: begin
                legal      = !(write && size == SZ_BYTE);
                vid_region = 1'b1;
            end
            RG_XWRAM: begin
                base  = word ? CNT_W'(XW_WIDE) : CNT_W'(XW_NARROW);
                half  = CNT_W'(XW_NARROW);
                split = word;
            end
            RG_PAL, RG_VRAM: begin
                legal      = !(write && size == SZ_BYTE);
                vid_region = 1'b1;
                base       = word ? CNT_W'(VID_WIDE) : CNT_W'(1);
                half       = CNT_W'(1);
                split      = word;
            end
            RG_CART: begin
                legal = !write;
                base  = word ? CNT_W'(CART_WIDE) : CNT_W'(CART_NARR);
                half  = CNT_W'(CART_NARR);
                split = word;
            end
            RG_SAVE: begin
                legal = (size == SZ_BYTE);
                base  = CNT_W'(SAVE_COST);
            end
            default: legal = 1'b0;
        endcase
        if (size == SZ_RSV) legal = 1'b0;
        if (!legal) begin
            base  = CNT_W'(1);
            split = 1'b0;
        end else if (vid_region && vid_busy) begin
            base = base + CNT_W'(1);
        end
        last = base - CNT_W'(1);
    end
endmodule

// File: rtl/mem_region_wait.sv
`timescale 1ns/1ps
module mem_region_wait
    import mrw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    input  logic                   req_write,
    input  logic                   req_seq,
    input  logic                   vid_busy,
    output logic [NUM_REGIONS-1:0] region_sel,
    output logic                   strobe,
    output logic [ADDR_W-1:0]      strobe_addr,
    output logic                   rdy,
    output logic                   err
);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    typedef struct packed {
        logic                   active;
        logic                   err;
        logic [NUM_REGIONS-1:0] sel;
        logic [CNT_W-1:0]       cnt;
        logic [CNT_W-1:0]       last;
        logic [CNT_W-1:0]       half;
        logic                   split;
        logic [ADDR_W-1:0]      addr;
    } state_t;

    state_t           st_d, st_q;
    region_e          dec_region;
    logic             c_legal, c_split;
    logic [CNT_W-1:0] c_last, c_half;
    logic             accept;
    logic             seq_unused;

    assign seq_unused = req_seq;

    region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (req_addr),
        .region (dec_region)
    );

    access_cost #(.CNT_W(CNT_W)) u_cost (
        .region   (dec_region),
        .size     (req_size),
        .write    (req_write),
        .vid_busy (vid_busy),
        .legal    (c_legal),
        .split    (c_split),
        .last     (c_last),
        .half     (c_half)
    );

    always_comb begin
        rdy         = st_q.active && (st_q.cnt == st_q.last);
        err         = st_q.active && st_q.err;
        region_sel  = st_q.active ? st_q.sel : '0;
        strobe      = st_q.active && !st_q.err &&
                      ((st_q.cnt == '0) || (st_q.split && st_q.cnt == st_q.half));
        strobe_addr = (st_q.cnt == '0) ? st_q.addr : st_q.addr + HALF_STEP;
        accept      = req_valid && (!st_q.active || rdy);

        st_d = st_q;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.err    = !c_legal;
            st_d.sel    = c_legal ? (NUM_REGIONS'(1) << dec_region) : '0;
            st_d.cnt    = '0;
            st_d.last   = c_last;
            st_d.half   = c_half;
            st_d.split  = c_split;
            st_d.addr   = req_addr;
        end else if (rdy) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: at most one region selected, and selection held until the final cycle
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));
    a_r1_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|region_sel && !rdy) |=> $stable(region_sel));
    // R8: an error completes at once with nothing selected or strobed
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdy && region_sel == '0 && !strobe));
    // R9: strobes only belong to a selected region
    a_r9_strobe_sel: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (|region_sel));
    // R10: ready is a single pulse unless a new request is chained
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !req_valid) |=> !rdy);
    // R10: a running access keeps its address while not finishing
    a_r10_no_midaccept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !rdy) |=> $stable(st_q.addr));
endmodule

// File: tb/mem_region_wait_tb_top.sv
`timescale 1ns/1ps
module mem_region_wait_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_seq = 1'b0;
    logic        vid_busy = 1'b0;
    logic [8:0]  region_sel;
    logic        strobe;
    logic [31:0] strobe_addr;
    logic        rdy;
    logic        err;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    mem_region_wait dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_seq(req_seq),
        .vid_busy(vid_busy), .region_sel(region_sel), .strobe(strobe),
        .strobe_addr(strobe_addr), .rdy(rdy), .err(err)
    );

    function automatic int region_of(input logic [31:0] a);
        if (a <= 32'h0000_3FFF) return 0;
        if (a >= 32'h0200_0000 && a <= 32'h0203_FFFF) return 1;
        if (a >= 32'h0300_0000 && a <= 32'h0300_7FFF) return 2;
        if (a >= 32'h0400_0000 && a <= 32'h0400_03FF) return 3;
        if (a >= 32'h0500_0000 && a <= 32'h0500_03FF) return 4;
        if (a >= 32'h0600_0000 && a <= 32'h0601_7FFF) return 5;
        if (a >= 32'h0700_0000 && a <= 32'h0700_03FF) return 6;
        if (a >= 32'h0800_0000 && a <= 32'h0DFF_FFFF) return 7;
        if (a >= 32'h0E00_0000 && a <= 32'h0E00_FFFF) return 8;
        return -1;
    endfunction

    task automatic check_idle(input string tag);
        vectors++;
        if (rdy !== 1'b0 || err !== 1'b0 || strobe !== 1'b0 || region_sel !== 9'd0) begin
            fails++;
            $display("FAIL %s idle: rdy=%b err=%b strobe=%b sel=%h, expected all 0",
                     tag, rdy, err, strobe, region_sel);
        end
    endtask

    // Entry and exit on a falling edge; exit is the rdy cycle of this access.
    task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic sq, input logic vid, input bit nag, input string tag);
        int rg, n, h;
        bit bad, wide;
        logic [8:0] esel;
        rg   = region_of(a);
        wide = (sz == 2'd2);
        bad  = (rg < 0) || (sz == 2'd3);
        if (wr && (rg == 0 || rg == 7)) bad = 1;
        if (wr && sz == 2'd0 && (rg == 4 || rg == 5 || rg == 6)) bad = 1;
        if (rg == 8 && sz != 2'd0) bad = 1;
        n = 1; h = -1;
        if (!bad) begin
            case (rg)
                1: begin n = wide ? 6 : 3; if (wide) h = 3; end
                4, 5: begin n = wide ? 2 : 1; if (wide) h = 1; end
                7: begin n = wide ? 8 : 5; if (wide) h = 5; end
                8: n = 5;
                default: n = 1;
            endcase
            if (vid && (rg == 4 || rg == 5 || rg == 6)) n = n + 1;
        end
        esel = bad ? 9'd0 : (9'd1 << rg);

        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        req_seq = sq; vid_busy = vid;
        @(negedge clk);
        req_valid = 1'b0; vid_busy = 1'b0;
        for (int k = 0; k < n; k++) begin
            bit est;
            logic [31:0] ead;
            if (nag) begin
                req_valid = (k < n - 1);
                req_addr  = 32'h0300_0010;
                req_size  = 2'd0;
            end
            est = !bad && (k == 0 || k == h);
            ead = (k == 0) ? a : a + 32'd2;
            vectors++;
            if (rdy !== (k == n - 1) || err !== (bad && k == n - 1) ||
                region_sel !== esel || strobe !== est ||
                (est && strobe_addr !== ead)) begin
                fails++;
                $display("FAIL %s cycle %0d: rdy=%b err=%b sel=%h stb=%b adr=%h, expected rdy=%b err=%b sel=%h stb=%b adr=%h",
                         tag, k, rdy, err, region_sel, strobe, strobe_addr,
                         (k == n - 1), (bad && k == n - 1), esel, est, ead);
            end
            if (k < n - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: 32-bit bus regions, one cycle
        run(32'h0000_0100, 2'd0, 0, 0, 0, 0, "R2 boot byte");
        run(32'h0000_3FFC, 2'd2, 0, 0, 0, 0, "R2 boot word");
        run(32'h0300_7FFC, 2'd2, 1, 0, 0, 0, "R2 iwram word write");
        run(32'h0400_0200, 2'd1, 1, 0, 0, 0, "R2 io half write");
        run(32'h0700_0000, 2'd0, 0, 0, 0, 0, "R2 oam byte read");
        run(32'h0700_03FE, 2'd1, 1, 0, 0, 0, "R2 oam half write");
        // R3 / R9
        run(32'h0200_0010, 2'd0, 0, 0, 0, 0, "R3 xwram byte");
        run(32'h0203_FFFC, 2'd2, 1, 0, 0, 0, "R3 R9 xwram word split");
        // R4 / R9
        run(32'h0500_0020, 2'd2, 1, 0, 0, 0, "R4 R9 palette word split");
        run(32'h0601_7FFE, 2'd1, 0, 0, 0, 0, "R4 vram half");
        // R5
        run(32'h0600_0040, 2'd2, 1, 0, 1, 0, "R5 vram word contention");
        run(32'h0700_0004, 2'd2, 0, 0, 1, 0, "R5 oam contention");
        run(32'h0500_0000, 2'd1, 0, 0, 1, 0, "R5 palette half contention");
        run(32'h0000_0000, 2'd2, 0, 0, 1, 0, "R5 boot ignores contention");
        run(32'h0200_0000, 2'd1, 0, 0, 1, 0, "R5 xwram ignores contention");
        // R6 / R11
        run(32'h0800_0000, 2'd1, 0, 0, 0, 0, "R6 cart half");
        run(32'h0DFF_FFFC, 2'd2, 0, 1, 0, 0, "R6 R9 R11 cart word seq");
        run(32'h0800_1000, 2'd2, 0, 0, 0, 0, "R6 R11 cart word nonseq");
        // R7
        run(32'h0E00_FFFF, 2'd0, 1, 0, 0, 0, "R7 save byte write");
        run(32'h0E00_0000, 2'd0, 0, 1, 0, 0, "R7 R11 save byte read");
        // R8
        run(32'h0E00_0002, 2'd1, 0, 0, 0, 0, "R8 save half read");
        run(32'h0000_0010, 2'd2, 1, 0, 0, 0, "R8 boot write");
        run(32'h0900_0000, 2'd1, 1, 0, 0, 0, "R8 cart write");
        run(32'h0500_0001, 2'd0, 1, 0, 1, 0, "R8 palette byte write");
        run(32'h0700_0001, 2'd0, 1, 0, 0, 0, "R8 oam byte write");
        run(32'h0100_0000, 2'd0, 0, 0, 0, 0, "R8 unmapped page");
        run(32'h0000_4000, 2'd0, 0, 0, 0, 0, "R8 past boot end");
        run(32'h0601_8000, 2'd1, 0, 0, 0, 0, "R8 past vram end");
        run(32'h1000_0000, 2'd0, 0, 0, 0, 0, "R8 high nibble");
        run(32'h0300_0000, 2'd3, 0, 0, 0, 0, "R8 reserved size");
        run(32'h0E01_0000, 2'd0, 0, 0, 0, 0, "R8 past save end");
        // R10: idle gap, then requests during a busy access are ignored
        @(negedge clk);
        check_idle("R10 gap");
        run(32'h0800_0100, 2'd2, 0, 0, 0, 1, "R10 busy ignores request");
        @(negedge clk);
        check_idle("R10 after busy");
        run(32'h0200_0100, 2'd2, 0, 0, 0, 1, "R10 busy xwram");
        @(negedge clk);
        check_idle("R10 after xwram");
        req_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule